// File: doc/BRIEF.md
# Switch-on-Stall Thread Issue Selector

This block sits in the issue stage of a scalar, in-order pipeline that runs several hardware threads. Each thread gives it one candidate instruction per cycle: a valid bit, an operation kind, two source register numbers and a destination register number. Every thread has its own register set and its own scoreboard of registers waiting on a load. A load is marked pending when it issues and cleared when its writeback event returns with the matching thread and register. The load may take any number of cycles, because its time in the cache varies.

In each cycle the block finds which threads can issue without a read-after-load hazard. It then picks one of them in round-robin order, starting from the thread after the one that issued last. A blocked thread never costs an issue slot. The selector moves on through the other threads in the same cycle. It reports a bubble only when no thread can issue. The outputs are combinational from the current inputs and the registered scoreboard, so the chosen thread ID is valid in the cycle it is computed.

Top module: `thread_issue_sel`

## Requirements
- R1: While reset is low, `iss_vld` and `bubble` are both 0. After reset, no register is pending and the first round-robin search starts at thread 0.
- R2: Kind encoding: 0 is an arithmetic operation (reads A and B, writes D), 1 is a load (reads A, writes D), 2 is a store (reads A and B, writes nothing), and 3 reads and writes nothing. A valid kind-3 instruction is always ready.
- R3: When a kind-1 instruction of thread t issues, register D of thread t becomes pending. A later instruction of thread t that reads that register is not issued until a writeback with `wb_tid`=t and `wb_reg`=D arrives.
- R4: Scoreboards are private to each thread. A register pending in one thread never blocks another thread, and a writeback naming another thread does not clear it.
- R5: A writeback in the same cycle as a dependent instruction makes that instruction ready in that cycle.
- R6: If at least one thread is ready, `iss_vld` is 1 in that cycle and `iss_tid` names a ready thread.
- R7: Among ready threads, the first one found searching upward (with wrap) from the thread after the last issued thread is chosen.
- R8: A thread whose `instr_vld` bit is 0 is never selected.
- R9: Out of reset, `bubble` is 1 exactly in the cycles where `iss_vld` is 0.
- R10: If a load to register D issues in the same cycle as a writeback for D of the same thread, D stays pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_vld | input | NTHR | Per-thread candidate instruction valid |
| instr_kind | input | 2*NTHR | Per-thread operation kind, thread t at bits [2t+1:2t] |
| instr_src_a | input | RIDX_W*NTHR | Per-thread source A register number |
| instr_src_b | input | RIDX_W*NTHR | Per-thread source B register number |
| instr_dst | input | RIDX_W*NTHR | Per-thread destination register number |
| wb_vld | input | 1 | Load writeback event |
| wb_tid | input | TID_W | Thread of the writeback |
| wb_reg | input | RIDX_W | Register written back |
| iss_vld | output | 1 | An instruction issues this cycle |
| iss_tid | output | TID_W | Thread chosen to issue |
| bubble | output | 1 | No thread can issue this cycle |

## Verification
The directed sequences cover a load followed by a dependent instruction in the same thread. They vary the state of the other thread: absent, independent, or reading the same register number. This separates a private scoreboard from a shared one and a switch from a stall. Writebacks come in the same cycle as the dependent read, for the wrong thread, and in the same cycle as a new load to that register. These show the same-cycle bypass, the thread matching, and set-over-clear priority. A long pseudo-random sweep uses only four register numbers, so hazards are dense. It compares every cycle's choice with a bench model of round-robin order over ready threads, which detects a wrong start point or a lost slot.

// File: rtl/thr_issue_pkg.sv
// Shared kind encoding and source-use decode for the thread issue selector.
// Assumes a 2-bit kind field per instruction.
package thr_issue_pkg;
    typedef enum logic [1:0] {
        KIND_ALU   = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_NONE  = 2'd3
    } op_kind_e;

    // True when the kind reads source A.
    function automatic logic uses_src_a(logic [1:0] kind);
        return kind != 2'(KIND_NONE);
    endfunction

    // True when the kind reads source B.
    function automatic logic uses_src_b(logic [1:0] kind);
        return (kind == 2'(KIND_ALU)) || (kind == 2'(KIND_STORE));
    endfunction
endpackage

// File: rtl/thr_scoreboard.sv
// Pending-load scoreboard for one thread: one bit per register.
// pend_eff already has the current writeback removed, so that a same-cycle
// read sees the written value. A set in the same cycle as a clear wins.
module thr_scoreboard #(
    parameter int NREG   = 32,
    parameter int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [RIDX_W-1:0] set_idx,
    input  logic              clr_en,
    input  logic [RIDX_W-1:0] clr_idx,
    output logic [NREG-1:0]   pend_eff
);
    logic [NREG-1:0] pend_q;

    // Remove the register written back this cycle from the visible set.
    always_comb begin
        pend_eff = pend_q;
        if (clr_en) pend_eff[clr_idx] = 1'b0;
    end

    // Store the cleared set plus any newly issued load destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_eff;
            if (set_en) pend_q[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/thr_hazard_chk.sv
// Readiness of one thread's candidate: valid and no read of a pending register.
// Assumes pend already reflects the same-cycle writeback bypass.
module thr_hazard_chk
    import thr_issue_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int RIDX_W = $clog2(NREG)
) (
    input  logic              vld,
    input  logic [1:0]        kind,
    input  logic [RIDX_W-1:0] src_a,
    input  logic [RIDX_W-1:0] src_b,
    input  logic [NREG-1:0]   pend,
    output logic              rdy
);
    logic haz_a, haz_b;

    // Hazard on each source only when the kind actually reads it.
    always_comb begin
        haz_a = uses_src_a(kind) && pend[src_a];
        haz_b = uses_src_b(kind) && pend[src_b];
        rdy   = vld && !haz_a && !haz_b;
    end
endmodule

// File: rtl/thr_rr_pick.sv
// Round-robin picker: first requester at or after 'start', with wrap.
// Assumes start < NTHR.
module thr_rr_pick #(
    parameter int NTHR  = 2,
    parameter int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic [NTHR-1:0]  req,
    input  logic [TID_W-1:0] start,
    output logic             gnt_vld,
    output logic [TID_W-1:0] gnt_id
);
    int idx;

    // Scan all threads once, starting at 'start', keeping the first hit.
    always_comb begin
        gnt_vld = 1'b0;
        gnt_id  = '0;
        idx     = 0;
        for (int i = 0; i < NTHR; i++) begin
            idx = int'(start) + i;
            if (idx >= NTHR) idx = idx - NTHR;
            if (!gnt_vld && req[idx]) begin
                gnt_vld = 1'b1;
                gnt_id  = TID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/thread_issue_sel.sv
// Switch-on-stall issue selector for NTHR threads with private register sets.
// Each cycle it picks, round-robin, a thread whose candidate has no
// read-after-load hazard; bubble only when all are blocked or invalid.
// Assumes loads are issued only through this selector and that each
// writeback names the thread and register of an earlier load.
module thread_issue_sel
    import thr_issue_pkg::*;
#(
    parameter int NTHR   = 2,
    parameter int NREG   = 32,
    parameter int RIDX_W = $clog2(NREG),
    parameter int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTHR-1:0]          instr_vld,
    input  logic [2*NTHR-1:0]        instr_kind,
    input  logic [RIDX_W*NTHR-1:0]   instr_src_a,
    input  logic [RIDX_W*NTHR-1:0]   instr_src_b,
    input  logic [RIDX_W*NTHR-1:0]   instr_dst,
    input  logic                     wb_vld,
    input  logic [TID_W-1:0]         wb_tid,
    input  logic [RIDX_W-1:0]        wb_reg,
    output logic                     iss_vld,
    output logic [TID_W-1:0]         iss_tid,
    output logic                     bubble
);
    logic [NTHR-1:0]  thr_rdy;
    logic [TID_W-1:0] rr_ptr;
    logic             pick_vld;
    logic [TID_W-1:0] pick_id;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [NREG-1:0] pend;
        logic            ld_set;
        logic            wb_hit;

        // A load of this thread issuing now, or a writeback aimed at it.
        always_comb begin
            ld_set = iss_vld && (pick_id == TID_W'(t)) &&
                     (instr_kind[2*t +: 2] == 2'(KIND_LOAD));
            wb_hit = wb_vld && (wb_tid == TID_W'(t));
        end

        thr_scoreboard #(.NREG(NREG), .RIDX_W(RIDX_W)) u_sb (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (ld_set),
            .set_idx  (instr_dst[RIDX_W*t +: RIDX_W]),
            .clr_en   (wb_hit),
            .clr_idx  (wb_reg),
            .pend_eff (pend)
        );

        thr_hazard_chk #(.NREG(NREG), .RIDX_W(RIDX_W)) u_hz (
            .vld   (instr_vld[t]),
            .kind  (instr_kind[2*t +: 2]),
            .src_a (instr_src_a[RIDX_W*t +: RIDX_W]),
            .src_b (instr_src_b[RIDX_W*t +: RIDX_W]),
            .pend  (pend),
            .rdy   (thr_rdy[t])
        );
    end

    thr_rr_pick #(.NTHR(NTHR), .TID_W(TID_W)) u_pick (
        .req     (thr_rdy),
        .start   (rr_ptr),
        .gnt_vld (pick_vld),
        .gnt_id  (pick_id)
    );

    // Outputs are quiet in reset; otherwise issue or bubble each cycle.
    always_comb begin
        iss_vld = rst_n && pick_vld;
        iss_tid = pick_id;
        bubble  = rst_n && !pick_vld;
    end

    // Next search starts at the thread after the one just issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (iss_vld) begin
            if (int'(pick_id) == NTHR - 1) rr_ptr <= '0;
            else                           rr_ptr <= pick_id + TID_W'(1);
        end
    end
endmodule

// File: rtl/thread_issue_sel_chk.sv
// Property checker for thread_issue_sel, bound into every instance.
// Observes ports plus the per-thread ready vector from the hazard checks.
module thread_issue_sel_chk
    import thr_issue_pkg::*;
#(
    parameter int NTHR   = 2,
    parameter int NREG   = 32,
    parameter int RIDX_W = $clog2(NREG),
    parameter int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NTHR-1:0]        instr_vld,
    input logic [2*NTHR-1:0]      instr_kind,
    input logic [RIDX_W*NTHR-1:0] instr_src_a,
    input logic [RIDX_W*NTHR-1:0] instr_src_b,
    input logic [RIDX_W*NTHR-1:0] instr_dst,
    input logic                   wb_vld,
    input logic [TID_W-1:0]       wb_tid,
    input logic [RIDX_W-1:0]      wb_reg,
    input logic                   iss_vld,
    input logic [TID_W-1:0]       iss_tid,
    input logic                   bubble,
    input logic [NTHR-1:0]        thr_rdy
);
    logic              ld_q;
    logic [TID_W-1:0]  ld_tid_q;
    logic [RIDX_W-1:0] ld_dst_q;
    logic              dep_now;
    logic [1:0]        dep_kind;

    // Remember a load issued in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q     <= 1'b0;
            ld_tid_q <= '0;
            ld_dst_q <= '0;
        end else begin
            ld_q     <= iss_vld && (instr_kind[2*iss_tid +: 2] == 2'(KIND_LOAD));
            ld_tid_q <= iss_tid;
            ld_dst_q <= instr_dst[RIDX_W*iss_tid +: RIDX_W];
        end
    end

    // Same thread now reads that destination with no writeback for it.
    always_comb begin
        dep_kind = instr_kind[2*ld_tid_q +: 2];
        dep_now  = ld_q && instr_vld[ld_tid_q] &&
                   ((uses_src_a(dep_kind) &&
                     instr_src_a[RIDX_W*ld_tid_q +: RIDX_W] == ld_dst_q) ||
                    (uses_src_b(dep_kind) &&
                     instr_src_b[RIDX_W*ld_tid_q +: RIDX_W] == ld_dst_q)) &&
                   !(wb_vld && wb_tid == ld_tid_q && wb_reg == ld_dst_q);
    end

    always @(negedge clk) begin
        if (!rst_n) AST_RESET_QUIET: assert (!iss_vld && !bubble); // R1
    end

    AST_PICK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> instr_vld[iss_tid]); // R8
    AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> thr_rdy[iss_tid]); // R6
    AST_NO_LOST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (|thr_rdy) |-> iss_vld); // R6
    AST_BUBBLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (thr_rdy == '0)); // R9
    AST_RR_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && $past(iss_vld) && iss_tid == $past(iss_tid))
            |-> ($countones(thr_rdy) == 1)); // R7
    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        dep_now |-> !thr_rdy[ld_tid_q]); // R3

    for (genvar t = 0; t < NTHR; t++) begin : g_none
        AST_NONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_vld[t] && instr_kind[2*t +: 2] == 2'(KIND_NONE))
                |-> thr_rdy[t]); // R2
    end
endmodule

bind thread_issue_sel thread_issue_sel_chk #(
    .NTHR(NTHR), .NREG(NREG), .RIDX_W(RIDX_W), .TID_W(TID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_kind(instr_kind),
    .instr_src_a(instr_src_a), .instr_src_b(instr_src_b), .instr_dst(instr_dst),
    .wb_vld(wb_vld), .wb_tid(wb_tid), .wb_reg(wb_reg), .iss_vld(iss_vld),
    .iss_tid(iss_tid), .bubble(bubble), .thr_rdy(thr_rdy)
);

// File: tb/tb_thread_issue_sel.sv
// Self-checking bench: directed hazard cases plus a dense pseudo-random sweep,
// each cycle compared against a scoreboard/round-robin model of the requirements.
module tb_thread_issue_sel;
    localparam int NTHR = 2;
    localparam int NREG = 32;
    localparam int RW   = 5;
    localparam int TW   = 1;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NTHR-1:0] instr_vld;
    logic [2*NTHR-1:0] instr_kind;
    logic [RW*NTHR-1:0] instr_src_a, instr_src_b, instr_dst;
    logic            wb_vld;
    logic [TW-1:0]   wb_tid;
    logic [RW-1:0]   wb_reg;
    logic            iss_vld;
    logic [TW-1:0]   iss_tid;
    logic            bubble;

    int checks = 0;
    int failures = 0;
    bit pend_m [NTHR][NREG];
    int ptr_m;
    bit done = 1'b0;

    thread_issue_sel #(.NTHR(NTHR), .NREG(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_kind(instr_kind),
        .instr_src_a(instr_src_a), .instr_src_b(instr_src_b), .instr_dst(instr_dst),
        .wb_vld(wb_vld), .wb_tid(wb_tid), .wb_reg(wb_reg),
        .iss_vld(iss_vld), .iss_tid(iss_tid), .bubble(bubble)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_thr(input int t, input bit v, input int kind,
                           input int a, input int b, input int d);
        instr_vld[t]          = v;
        instr_kind[2*t +: 2]  = 2'(kind);
        instr_src_a[RW*t +: RW] = RW'(a);
        instr_src_b[RW*t +: RW] = RW'(b);
        instr_dst[RW*t +: RW]   = RW'(d);
    endtask

    task automatic set_wb(input bit v, input int t, input int r);
        wb_vld = v;
        wb_tid = TW'(t);
        wb_reg = RW'(r);
    endtask

    // Compare one cycle against the model, then advance the model at the edge.
    task automatic step(input string tag);
        bit rdy [NTHR];
        bit ev;
        int et;
        #5;
        for (int t = 0; t < NTHR; t++) begin
            int k;
            bit pa, pb;
            k  = int'(instr_kind[2*t +: 2]);
            pa = pend_m[t][instr_src_a[RW*t +: RW]] &&
                 !(wb_vld && int'(wb_tid) == t && wb_reg == instr_src_a[RW*t +: RW]);
            pb = pend_m[t][instr_src_b[RW*t +: RW]] &&
                 !(wb_vld && int'(wb_tid) == t && wb_reg == instr_src_b[RW*t +: RW]);
            rdy[t] = instr_vld[t] && !((k != 3) && pa) && !((k == 0 || k == 2) && pb);
        end
        ev = 1'b0;
        et = 0;
        for (int i = 0; i < NTHR; i++) begin
            int idx;
            idx = (ptr_m + i) % NTHR;
            if (!ev && rdy[idx]) begin ev = 1'b1; et = idx; end
        end
        chk(iss_vld == ev, {tag, " iss_vld"}, int'(iss_vld), int'(ev));
        chk(bubble == !ev, {tag, " R9 bubble"}, int'(bubble), int'(!ev));
        if (ev) chk(int'(iss_tid) == et, {tag, " iss_tid"}, int'(iss_tid), et);
        @(posedge clk);
        if (wb_vld) pend_m[int'(wb_tid)][wb_reg] = 1'b0;
        if (ev) begin
            ptr_m = (et + 1) % NTHR;
            if (instr_kind[2*et +: 2] == 2'd1) pend_m[et][instr_dst[RW*et +: RW]] = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned lfsr;
        rst_n = 1'b0;
        instr_vld = '0; instr_kind = '0;
        instr_src_a = '0; instr_src_b = '0; instr_dst = '0;
        set_wb(0, 0, 0);
        for (int t = 0; t < NTHR; t++) for (int r = 0; r < NREG; r++) pend_m[t][r] = 1'b0;
        ptr_m = 0;
        set_thr(0, 1, 3, 0, 0, 0);
        set_thr(1, 1, 3, 0, 0, 0);
        repeat (3) @(negedge clk);
        #5;
        chk(!iss_vld, "R1 reset iss_vld", int'(iss_vld), 0);
        chk(!bubble, "R1 reset bubble", int'(bubble), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: first pick after reset is thread 0; R7 alternation follows.
        step("R1 first pick");
        step("R7 alternate");
        step("R7 alternate back");

        // R3/R9: load in thread 0, then dependent read while thread 1 idle.
        set_thr(1, 0, 3, 0, 0, 0);
        set_thr(0, 1, 1, 1, 0, 5);
        step("R3 load issues");
        set_thr(0, 1, 0, 5, 2, 6);
        step("R3 dependent blocked");
        // R6: another thread ready takes the slot in the same cycle.
        set_thr(1, 1, 3, 0, 0, 0);
        step("R6 switch on stall");
        // R4: thread 1 reading register 5 is independent.
        set_thr(1, 1, 0, 5, 5, 9);
        step("R4 private regs");
        // R8: invalid thread never selected even if its kind would be ready.
        set_thr(1, 0, 3, 0, 0, 0);
        step("R8 invalid thread");
        // R4: writeback naming thread 1 does not release thread 0.
        set_wb(1, 1, 5);
        step("R4 wrong-thread wb");
        // R5: matching writeback in the same cycle makes it ready.
        set_wb(1, 0, 5);
        step("R5 same-cycle wb");
        set_wb(0, 0, 0);
        step("R5 released");

        // R2: store reads B; register 31 boundary.
        set_thr(0, 1, 1, 0, 0, 31);
        step("R2 load r31");
        set_thr(0, 1, 2, 3, 31, 0);
        step("R2 store reads B");
        set_thr(0, 1, 1, 31, 4, 8);
        step("R2 load reads A");
        set_thr(0, 1, 1, 4, 31, 8);
        step("R2 load ignores B");
        set_wb(1, 0, 31);
        set_thr(0, 1, 3, 31, 31, 0);
        step("R2 kind3 reads none");
        set_wb(0, 0, 0);

        // R10: new load to a pending register with its writeback same cycle.
        set_thr(0, 1, 1, 0, 0, 7);
        step("R10 first load");
        set_wb(1, 0, 7);
        set_thr(0, 1, 1, 0, 0, 7);
        step("R10 reload with wb");
        set_wb(0, 0, 0);
        set_thr(0, 1, 0, 7, 0, 1);
        step("R10 still pending");
        set_wb(1, 0, 7);
        step("R10 cleared");
        set_wb(0, 0, 0);

        // R6/R7: dense pseudo-random sweep on four registers.
        lfsr = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            for (int t = 0; t < NTHR; t++) begin
                lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
                set_thr(t, (lfsr[3:0] != 4'd0), int'(lfsr[5:4]), int'(lfsr[7:6]),
                        int'(lfsr[9:8]), int'(lfsr[11:10]));
            end
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            set_wb(lfsr[1:0] == 2'd0, int'(lfsr[2]), int'(lfsr[4:3]));
            step("R6 R7 sweep");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule